// File: doc/BRIEF.md
# DSI Video-Mode Line Sequencer

This block produces the ordered stream of timing tokens that a DSI video-mode transmitter needs for every line and every frame. A pixel clock does not drive it. Horizontal intervals are programmed as byte word counts and vertical intervals as line counts. Three video modes are supported: sync events, sync pulses and burst. The selected mode decides which horizontal fields are used and in what order the tokens come out. Packet header, ECC and CRC formation, lane distribution and the physical layer sit downstream and are not part of this block.

Each token carries a 3-bit type code, a 16-bit length and an 8-bit data byte. Tokens leave on a valid/ready interface. The sequencer moves to the next token only when the current one has been accepted. While `tok_ready` is low the token is held unchanged, so back-pressure delays the stream without losing anything. Active payload bytes are pulled from a valid/ready pixel source, one byte per accepted DATA token. The pixel side can never stall the line. If the source has no byte ready, a zero goes out and a sticky underflow flag is set.

Timing fields are written into a staging copy through a plain write port. The staged values, together with the video mode, are copied into the working set only at a frame boundary, so a single frame never mixes old and new timing.

Top module: `dsi_line_seq`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `cfg_err`, `underflow` and `pix_ready` are 0. On that first cycle `tok_valid` is 1 and the token is a vertical-sync start (type 3, length 0). The working timing after reset is HSA=2, BLLP=5, HACT=6, HBP=1, HFP=4, VSA=1, VBP=1, VACT=2, VFP=1, in sync-event mode.
- R2: A write (`cfg_we`=1) goes to the staging word chosen by `cfg_sel`. Word 0 holds HSA in [15:0] and BLLP in [31:16]. Word 1 holds HACT in [15:0] and VACT in [25:16]. Word 2 holds HBP in [15:0] and HFP in [31:16]. Word 3 holds VSA in [9:0], VBP in [19:10] and VFP in [29:20].
- R3: In sync-event mode (`vid_mode`=0) an active line is: horizontal-sync start (type 1, length 0), BLANK (type 5) of HBP, payload header (type 6) of HACT, HACT DATA tokens, then BLANK of HFP. HSA and BLLP have no effect in this mode.
- R4: In sync-pulse mode (`vid_mode`=1) every line inserts BLANK of HSA and then a sync end right after its sync start. The sync end is type 2 on horizontal lines and type 4 on VSA lines.
- R5: In burst mode (`vid_mode`=2) an active line is: sync start, BLANK of HBP, payload header, HACT consecutive DATA tokens, BLANK of BLLP, then BLANK of HFP. HSA has no effect in this mode.
- R6: A line outside the active region is a sync start (type 3 on VSA lines, type 1 otherwise), the mode's pulse steps if any, then one BLANK whose length is HBP+HACT+HFP modulo 65536.
- R7: A frame is VSA lines, then VBP lines, then VACT lines, then VFP lines, and then the next frame begins. A region whose count is 0 contributes no lines.
- R8: Staged timing and the `vid_mode` input take effect only from the first line of the next frame. A write made during a frame leaves that frame unchanged.
- R9: While `fmt_rgb888` is 1, a write to word 1 whose HACT is not a multiple of three sets the sticky `cfg_err`. The staged HACT keeps its previous value, and the VACT field of that same write is still taken.
- R10: If a DATA token is accepted while `pix_valid` is 0, its data byte is 0 and `underflow` becomes 1 and stays 1 until reset. The line continues with no added tokens and no delay.
- R11: While `tok_valid` is 1 and `tok_ready` is 0, the token type and length do not change and `tok_valid` stays 1.
- R12: Each DATA token has type 7 and length 1, and carries `pix_data` when `pix_valid` is 1. `pix_ready` is 1 exactly in the cycle a DATA token is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_sel | input | 2 | Staging word select |
| cfg_wdata | input | 32 | Staging write data |
| vid_mode | input | 2 | 0 sync events, 1 sync pulses, 2 burst (3 behaves as 0) |
| fmt_rgb888 | input | 1 | Enables the HACT multiple-of-three rule |
| pix_valid | input | 1 | Pixel source has a byte |
| pix_ready | output | 1 | Pixel byte consumed this cycle |
| pix_data | input | 8 | Pixel byte |
| tok_valid | output | 1 | Token present |
| tok_ready | input | 1 | Downstream accepts the token |
| tok_type | output | 3 | Token type code |
| tok_len | output | 16 | Token length in bytes |
| tok_data | output | 8 | Payload byte for DATA tokens |
| cfg_err | output | 1 | Sticky illegal-HACT flag |
| underflow | output | 1 | Sticky pixel underflow flag |

## Verification
Two things can land in the same cycle: a pixel underflow and the hand-over from payload to trailing blanking. This happens when the source drops `pix_valid` exactly on the final DATA beat of a line, which is the acceptance that also moves the step to BLLP or HFP. The bench withholds the pixel only for that last beat of the first active line in a burst frame. It then judges the result on three points: the byte must be zero, `underflow` must be set right after that acceptance, and the BLLP and HFP blanking tokens must follow at once with their programmed lengths. The next frame confirms that the flag has stayed set.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
  localparam int HW = 16;
  localparam int VW = 10;

  typedef struct packed {
    logic [HW-1:0] hsa;
    logic [HW-1:0] bllp;
    logic [HW-1:0] hact;
    logic [HW-1:0] hbp;
    logic [HW-1:0] hfp;
    logic [VW-1:0] vsa;
    logic [VW-1:0] vbp;
    logic [VW-1:0] vact;
    logic [VW-1:0] vfp;
  } tmg_t;

  typedef enum logic [1:0] {VM_EVENT = 2'd0, VM_PULSE = 2'd1, VM_BURST = 2'd2, VM_RSVD = 2'd3} vmode_e;

  typedef enum logic [2:0] {
    TK_NONE = 3'd0, TK_HSTART = 3'd1, TK_HEND = 3'd2, TK_VSTART = 3'd3,
    TK_VEND = 3'd4, TK_BLANK = 3'd5, TK_PAYHDR = 3'd6, TK_DATA = 3'd7
  } tok_e;

  typedef enum logic [1:0] {RG_VSA = 2'd0, RG_VBP = 2'd1, RG_VACT = 2'd2, RG_VFP = 2'd3} region_e;

  localparam tmg_t TMG_RST = '{
    hsa: 16'd2, bllp: 16'd5, hact: 16'd6, hbp: 16'd1, hfp: 16'd4,
    vsa: 10'd1, vbp: 10'd1, vact: 10'd2, vfp: 10'd1
  };
endpackage

// File: rtl/dsi_seq_regs.sv
module dsi_seq_regs
  import dsi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        fmt_rgb888,
  input  logic [1:0]  vid_mode,
  input  logic        frame_start,
  output tmg_t        act,
  output vmode_e      mode_act,
  output logic        cfg_err
);
  tmg_t stg;
  logic hact_ok;

  assign hact_ok = !fmt_rgb888 || ((cfg_wdata[HW-1:0] % HW'(3)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg      <= TMG_RST;
      act      <= TMG_RST;
      mode_act <= VM_EVENT;
      cfg_err  <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            stg.hsa  <= cfg_wdata[HW-1:0];
            stg.bllp <= cfg_wdata[2*HW-1:HW];
          end
          2'd1: begin
            if (hact_ok) stg.hact <= cfg_wdata[HW-1:0];
            else         cfg_err  <= 1'b1;
            stg.vact <= cfg_wdata[HW +: VW];
          end
          2'd2: begin
            stg.hbp <= cfg_wdata[HW-1:0];
            stg.hfp <= cfg_wdata[2*HW-1:HW];
          end
          default: begin
            stg.vsa <= cfg_wdata[0 +: VW];
            stg.vbp <= cfg_wdata[VW +: VW];
            stg.vfp <= cfg_wdata[2*VW +: VW];
          end
        endcase
      end
      if (frame_start) begin
        act      <= stg;
        mode_act <= vmode_e'(vid_mode);
      end
    end
  end

  // R9
  hact_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == 2'd1 && !hact_ok |=> cfg_err && $stable(stg.hact));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act) && $stable(mode_act));
endmodule

// File: rtl/dsi_seq_vcount.sv
module dsi_seq_vcount
  import dsi_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vsa,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vfp,
  input  logic          line_done,
  output logic          line_ok,
  output logic          active_line,
  output logic          vsync_line,
  output logic          frame_start
);
  region_e       region;
  logic [VW-1:0] line_cnt;
  logic [VW-1:0] rcnt;
  logic          adv, last;

  always_comb begin
    case (region)
      RG_VSA:  rcnt = vsa;
      RG_VBP:  rcnt = vbp;
      RG_VACT: rcnt = vact;
      default: rcnt = vfp;
    endcase
  end

  assign line_ok     = rcnt != '0;
  assign adv         = line_done || !line_ok;
  assign last        = !line_ok || (line_cnt == rcnt - VW'(1));
  assign frame_start = adv && last && region == RG_VFP;
  assign active_line = region == RG_VACT;
  assign vsync_line  = region == RG_VSA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region   <= RG_VSA;
      line_cnt <= '0;
    end else if (adv) begin
      if (last) begin
        line_cnt <= '0;
        region   <= region_e'(region + 2'd1);
      end else begin
        line_cnt <= line_cnt + VW'(1);
      end
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> line_cnt < rcnt);

  // R7
  done_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> line_ok);
endmodule

// File: rtl/dsi_seq_hstep.sv
module dsi_seq_hstep
  import dsi_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hsa,
  input  logic [HW-1:0] bllp,
  input  logic [HW-1:0] hact,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hfp,
  input  vmode_e        mode,
  input  logic          line_ok,
  input  logic          active_line,
  input  logic          vsync_line,
  input  logic          tok_ready,
  input  logic          pix_valid,
  input  logic [7:0]    pix_data,
  output logic          tok_valid,
  output tok_e          tok_type,
  output logic [HW-1:0] tok_len,
  output logic [7:0]    tok_data,
  output logic          pix_ready,
  output logic          line_done,
  output logic          underflow
);
  typedef enum logic [3:0] {
    ST_SYNC, ST_HSA, ST_SEND, ST_HBP, ST_PAY, ST_DATA, ST_BLLP, ST_HFP, ST_VBLK
  } step_e;

  step_e         step, nxt;
  logic [HW-1:0] beat;
  logic          fire, is_pulse, is_burst;
  step_e         after_sync, after_pay;

  assign is_pulse   = mode == VM_PULSE;
  assign is_burst   = mode == VM_BURST;
  assign tok_valid  = line_ok;
  assign fire       = tok_valid && tok_ready;
  assign after_sync = active_line ? ST_HBP : ST_VBLK;
  assign after_pay  = is_burst ? ST_BLLP : ST_HFP;
  assign pix_ready  = fire && step == ST_DATA;
  assign line_done  = fire && (step == ST_HFP || step == ST_VBLK);
  assign tok_data   = (step == ST_DATA && pix_valid) ? pix_data : 8'h00;

  always_comb begin
    tok_type = TK_BLANK;
    tok_len  = '0;
    nxt      = step;
    case (step)
      ST_SYNC: begin
        tok_type = vsync_line ? TK_VSTART : TK_HSTART;
        nxt      = is_pulse ? ST_HSA : after_sync;
      end
      ST_HSA: begin
        tok_len = hsa;
        nxt     = ST_SEND;
      end
      ST_SEND: begin
        tok_type = vsync_line ? TK_VEND : TK_HEND;
        nxt      = after_sync;
      end
      ST_HBP: begin
        tok_len = hbp;
        nxt     = ST_PAY;
      end
      ST_PAY: begin
        tok_type = TK_PAYHDR;
        tok_len  = hact;
        nxt      = (hact == '0) ? after_pay : ST_DATA;
      end
      ST_DATA: begin
        tok_type = TK_DATA;
        tok_len  = HW'(1);
        nxt      = (beat == hact - HW'(1)) ? after_pay : ST_DATA;
      end
      ST_BLLP: begin
        tok_len = bllp;
        nxt     = ST_HFP;
      end
      ST_HFP: begin
        tok_len = hfp;
        nxt     = ST_SYNC;
      end
      default: begin
        tok_len = hbp + hact + hfp;
        nxt     = ST_SYNC;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= ST_SYNC;
      beat      <= '0;
      underflow <= 1'b0;
    end else if (fire) begin
      step <= nxt;
      if (step == ST_PAY)  beat <= '0;
      if (step == ST_DATA) beat <= beat + HW'(1);
      if (step == ST_DATA && !pix_valid) underflow <= 1'b1;
    end
  end

  // R11
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ready |=> tok_valid && $stable(tok_type) && $stable(tok_len));

  // R10
  uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R10
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_type == TK_DATA && !pix_valid |-> tok_data == 8'h00);

  // R12
  pix_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> tok_valid && tok_ready && tok_type == TK_DATA);
endmodule

// File: rtl/dsi_line_seq.sv
module dsi_line_seq
  import dsi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic [1:0]  vid_mode,
  input  logic        fmt_rgb888,
  input  logic        pix_valid,
  output logic        pix_ready,
  input  logic [7:0]  pix_data,
  output logic        tok_valid,
  input  logic        tok_ready,
  output logic [2:0]  tok_type,
  output logic [15:0] tok_len,
  output logic [7:0]  tok_data,
  output logic        cfg_err,
  output logic        underflow
);
  tmg_t   act;
  vmode_e mode_act;
  tok_e   type_e;
  logic   frame_start, line_done, line_ok, active_line, vsync_line;

  dsi_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fmt_rgb888(fmt_rgb888), .vid_mode(vid_mode),
    .frame_start(frame_start), .act(act), .mode_act(mode_act), .cfg_err(cfg_err)
  );

  dsi_seq_vcount u_vcount (
    .clk(clk), .rst_n(rst_n), .vsa(act.vsa), .vbp(act.vbp), .vact(act.vact),
    .vfp(act.vfp), .line_done(line_done), .line_ok(line_ok),
    .active_line(active_line), .vsync_line(vsync_line), .frame_start(frame_start)
  );

  dsi_seq_hstep u_hstep (
    .clk(clk), .rst_n(rst_n), .hsa(act.hsa), .bllp(act.bllp), .hact(act.hact),
    .hbp(act.hbp), .hfp(act.hfp), .mode(mode_act), .line_ok(line_ok),
    .active_line(active_line), .vsync_line(vsync_line), .tok_ready(tok_ready),
    .pix_valid(pix_valid), .pix_data(pix_data), .tok_valid(tok_valid),
    .tok_type(type_e), .tok_len(tok_len), .tok_data(tok_data),
    .pix_ready(pix_ready), .line_done(line_done), .underflow(underflow)
  );

  assign tok_type = type_e;
endmodule

// File: tb/dsi_line_seq_bench.sv
module dsi_line_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [1:0]  vid_mode = 2'd0;
  logic        fmt_rgb888 = 1'b1;
  logic        pix_valid = 1'b1;
  logic        pix_ready;
  logic [7:0]  pix_data = 8'hA5;
  logic        tok_valid;
  logic        tok_ready = 1'b0;
  logic [2:0]  tok_type;
  logic [15:0] tok_len;
  logic [7:0]  tok_data;
  logic        cfg_err, underflow;

  int checks = 0;
  int fails = 0;
  int stall_n = 0;
  int pend_n = 0;
  logic [1:0]  pend_sel [4];
  logic [31:0] pend_dat [4];
  logic [1:0]  pend_mode = 2'd0;

  always #5 clk = ~clk;

  dsi_line_seq u_dsi_line_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .vid_mode(vid_mode), .fmt_rgb888(fmt_rgb888),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_type(tok_type),
    .tok_len(tok_len), .tok_data(tok_data), .cfg_err(cfg_err), .underflow(underflow)
  );

  task automatic note(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] dat);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = dat;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply_pend();
    vid_mode = pend_mode;
    for (int i = 0; i < pend_n; i++) wr(pend_sel[i], pend_dat[i]);
    pend_n = 0;
  endtask

  task automatic next_tok(output int ty, output int ln, output int dt);
    @(negedge clk);
    while (!tok_valid) @(negedge clk);
    if (stall_n > 0) begin
      int t0, l0;
      t0 = tok_type; l0 = tok_len;
      for (int k = 0; k < stall_n; k++) begin
        @(negedge clk);
        note(tok_valid && tok_type == t0 && tok_len == l0, "R11", "held token type", tok_type, t0);
      end
      stall_n = 0;
    end
    tok_ready = 1'b1;
    ty = tok_type; ln = tok_len; dt = tok_data;
    @(posedge clk);
    #1 tok_ready = 1'b0;
  endtask

  task automatic expect_tok(input int ety, input int eln, input int edt, input string tag);
    int ty, ln, dt;
    next_tok(ty, ln, dt);
    note(ty == ety, tag, "token type", ty, ety);
    note(ln == eln, tag, "token length", ln, eln);
    if (ety == 7) note(dt == edt, tag, "data byte", dt, edt);
  endtask

  task automatic check_frame(input int mode, input int hsa, input int bllp, input int hact,
                             input int hbp, input int hfp, input int vsa, input int vbp,
                             input int vact, input int vfp, input bit do_pend, input bit drop);
    bit first;
    int n;
    first = 1'b1;
    for (int r = 0; r < 4; r++) begin
      n = (r == 0) ? vsa : (r == 1) ? vbp : (r == 2) ? vact : vfp;
      for (int l = 0; l < n; l++) begin
        expect_tok((r == 0) ? 3 : 1, 0, 0, "R7");
        if (first && do_pend) apply_pend();
        first = 1'b0;
        if (mode == 1) begin
          expect_tok(5, hsa, 0, "R4");
          expect_tok((r == 0) ? 4 : 2, 0, 0, "R4");
        end
        if (r == 2) begin
          expect_tok(5, hbp, 0, "R3");
          expect_tok(6, hact, 0, "R12");
          for (int b = 0; b < hact; b++) begin
            bit d;
            d = drop && l == 0 && b == hact - 1;
            pix_valid = !d;
            expect_tok(7, 1, d ? 0 : 8'hA5, d ? "R10" : "R12");
            pix_valid = 1'b1;
            if (d) note(underflow == 1'b1, "R10", "underflow set", underflow, 1);
          end
          if (mode == 2) expect_tok(5, bllp, 0, "R5");
          expect_tok(5, hfp, 0, "R3");
        end else begin
          expect_tok(5, (hbp + hact + hfp) % 65536, 0, "R6");
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    note(cfg_err == 1'b0 && underflow == 1'b0 && pix_ready == 1'b0, "R1", "flags in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    note(tok_valid == 1'b1, "R1", "tok_valid after reset", tok_valid, 1);
    note(tok_type == 3'd3 && tok_len == 16'd0, "R1", "first token type", tok_type, 3);
    note(cfg_err == 1'b0 && underflow == 1'b0, "R1", "flags after reset", cfg_err, 0);
  endtask

  task automatic t_events_and_stage();
    // R2 R8: stage new timing and pulse mode during a default sync-event frame
    pend_sel[0] = 2'd0; pend_dat[0] = 32'h0003_0002;
    pend_sel[1] = 2'd1; pend_dat[1] = 32'h0002_0003;
    pend_sel[2] = 2'd2; pend_dat[2] = 32'h0002_0001;
    pend_sel[3] = 2'd3; pend_dat[3] = 32'h0010_0401;
    pend_n = 4; pend_mode = 2'd1;
    check_frame(0, 2, 5, 6, 1, 4, 1, 1, 2, 1, 1'b1, 1'b0);
  endtask

  task automatic t_pulse();
    pend_n = 0; pend_mode = 2'd2;
    check_frame(1, 2, 3, 3, 1, 2, 1, 1, 2, 1, 1'b1, 1'b0);
    note(cfg_err == 1'b0, "R9", "no error on legal writes", cfg_err, 0);
  endtask

  task automatic t_burst_bad_hact();
    // R9: HACT 7 refused, VACT 1 taken; R7: VBP 0 skipped, VFP 2
    pend_sel[0] = 2'd1; pend_dat[0] = 32'h0001_0007;
    pend_sel[1] = 2'd3; pend_dat[1] = 32'h0020_0001;
    pend_n = 2; pend_mode = 2'd2;
    check_frame(2, 2, 3, 3, 1, 2, 1, 1, 2, 1, 1'b1, 1'b0);
    note(cfg_err == 1'b1, "R9", "cfg_err after bad HACT", cfg_err, 1);
  endtask

  task automatic t_underflow_stall();
    note(underflow == 1'b0, "R10", "underflow clear before drop", underflow, 0);
    pend_n = 0; pend_mode = 2'd0;
    stall_n = 3;
    check_frame(2, 2, 3, 3, 1, 2, 1, 0, 1, 2, 1'b1, 1'b1);
  endtask

  task automatic t_sticky();
    check_frame(0, 2, 3, 3, 1, 2, 1, 0, 1, 2, 1'b0, 1'b0);
    note(underflow == 1'b1, "R10", "underflow sticky", underflow, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11: actual stalled expected progress");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_events_and_stage();
    t_pulse();
    t_burst_bad_hact();
    t_underflow_stall();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule